// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a single-ported cache controller built from a direct-mapped line array and a small fully-associative victim buffer that stands between that array and the next level of memory. A line is one data word. Every valid line that leaves the direct-mapped array goes into the buffer instead of being dropped. A request that misses the array is then looked up in the buffer in a separate cycle. When the buffer holds the line, the line moves back into the array. The line it displaces takes over the freed buffer slot in the same step. Two addresses that share a set and are used in turn therefore keep hitting on chip.

The block takes one request at a time on the request port. Writes allocate on a miss. When both structures miss, the controller reads the line from the next level. If the buffer slot chosen for the displaced line holds a dirty line, that line is written back first.

Top module: `dmvc_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, mem_req_valid is 0, and every line is invalid, so the first access to any address misses.
- R2: A read that hits the direct-mapped array asserts resp_valid in the cycle after acceptance, with the stored word on resp_rdata, and makes no next-level request.
- R3: Writes allocate on a miss. A write sets the line's dirty flag. The response to a write returns the written word on resp_rdata.
- R4: When both the array and the buffer miss, exactly one next-level read (mem_req_write 0) is issued at the request address. With a memory that accepts at once and answers in the following cycle, the response comes 5 cycles after acceptance, or 6 when a write-back comes first. The request is held stable until mem_req_ready.
- R5: A valid line displaced from the array on a miss enters the buffer. A later access to that line is served from the buffer with no next-level traffic.
- R6: A buffer hit responds 3 cycles after acceptance with no next-level traffic. The line moves into the array, so an immediate repeat hits in 1 cycle. The displaced array line takes the freed slot.
- R7: Two lines with the same index that are accessed alternately are both served with no next-level traffic once both are loaded.
- R8: The dirty flag travels with a line through every swap and insertion. Only dirty lines are written back, and a clean line pushed out of the buffer is dropped without any write.
- R9: A line entering the buffer on a miss takes the lowest-numbered invalid slot. When every slot is valid, it takes the slot named by a rotating pointer, which then advances modulo the depth. A dirty occupant of that slot is written to the next level (mem_req_write 1, its own address and data) before the fill read is issued.
- R10: req_ready is 0 from acceptance through the response cycle and is 1 again in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line (word) address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DATA_W | Read data, or the written word for a write |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = line fill read |
| mem_req_addr | output | ADDR_W | Next-level line address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_resp_valid | input | 1 | Fill data present |
| mem_resp_rdata | input | DATA_W | Fill data |

## Verification
If the array and the buffer disagree about where a line lives, the error shows up as a wrong response latency on the very next access to that line. A buffer hit turns into a 5-cycle miss, or a miss shows up as a 1-cycle hit, and an unexpected fill read appears on the memory port. A dirty flag lost during a swap only shows much later, when the line is pushed out of the buffer: the expected write-back is missing, or a write-back appears that should not. The long conflict sequences and the random phase are there to bring that eviction within reach. A wrong rotating pointer shows up as a write-back carrying the wrong address on the first eviction from a full buffer.

// File: rtl/dmvc_pkg.sv
// Shared types for the direct-mapped cache with victim buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package dmvc_pkg;

    // Controller states, one request in flight at a time.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_LOOK,   // direct-mapped tag compare
        ST_PROBE,  // victim buffer lookup
        ST_SWAP,   // exchange array line and buffer line
        ST_WBACK,  // write dirty buffer victim to next level
        ST_FILL,   // issue fill read
        ST_WAIT,   // wait for fill data
        ST_DONE    // install fetched line, respond
    } st_e;

endpackage

// File: rtl/dmvc_main_arr.sv
// Direct-mapped line store: valid, dirty, tag and data per line.
// Read is combinational on rd_idx. One write port updates a whole line.
// Assumes: a write installs a valid line; only valid/dirty are reset.
module dmvc_main_arr #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dirty,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  line_valid;
    logic [LINES-1:0]  line_dirty;
    logic [TAG_W-1:0]  line_tag  [LINES];
    logic [DATA_W-1:0] line_data [LINES];

    // Combinational read of the addressed line.
    always_comb begin
        rd_valid = line_valid[rd_idx];
        rd_dirty = line_dirty[rd_idx];
        rd_tag   = line_tag[rd_idx];
        rd_data  = line_data[rd_idx];
    end

    // Status bits: cleared by reset, set by line writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= '0;
            line_dirty <= '0;
        end else if (wr_en) begin
            line_valid[wr_idx] <= 1'b1;
            line_dirty[wr_idx] <= wr_dirty;
        end
    end

    // Tag and data payload, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_tag[wr_idx]  <= wr_tag;
            line_data[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/dmvc_victim_buf.sv
// Fully-associative victim buffer. It matches a probe address against all
// entries, proposes an insertion slot (lowest invalid, else rotating pointer)
// and has one read port and one write port addressed by slot.
// Assumes: at most one entry matches (the controller keeps lines exclusive).
module dmvc_victim_buf #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic              full,
    output logic [SLOT_W-1:0] vic_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ptr_adv
);
    logic [DEPTH-1:0]  ent_valid;
    logic [DEPTH-1:0]  ent_dirty;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [DEPTH-1:0]  match;
    logic [SLOT_W-1:0] rr_ptr;

    // One comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_addr[g] == probe_addr);
    end

    assign hit  = |match;
    assign full = &ent_valid;

    // Encode the matching entry.
    always_comb begin
        hit_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = SLOT_W'(i);
        end
    end

    // Insertion slot: lowest invalid entry, else the rotating pointer.
    always_comb begin
        vic_slot = rr_ptr;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) vic_slot = SLOT_W'(i);
        end
    end

    // Read port by slot.
    always_comb begin
        rd_valid = ent_valid[rd_slot];
        rd_dirty = ent_dirty[rd_slot];
        rd_addr  = ent_addr[rd_slot];
        rd_data  = ent_data[rd_slot];
    end

    // Status bits and rotating pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_dirty <= '0;
            rr_ptr    <= '0;
        end else if (wr_en) begin
            ent_valid[wr_slot] <= wr_valid;
            ent_dirty[wr_slot] <= wr_dirty;
            if (ptr_adv)
                rr_ptr <= (rr_ptr == SLOT_W'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    // Address and data payload.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_addr[wr_slot] <= wr_addr;
            ent_data[wr_slot] <= wr_data;
        end
    end

endmodule

// File: rtl/dmvc_cache.sv
// Direct-mapped cache with victim buffer, top level and controller.
// Flow: accept -> array compare -> buffer probe -> swap, or
// [write-back] -> fill -> install. One request in flight.
// Assumes: one word per line; the next level returns fill data on
// mem_resp_valid some cycles after accepting the read.
module dmvc_cache #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int LINES    = 64,
    parameter int VB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata
);
    import dmvc_pkg::*;

    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int SLOT_W = $clog2(VB_DEPTH);

    st_e               st_q, st_d;
    logic              r_write;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [SLOT_W-1:0] s_slot;
    logic [DATA_W-1:0] f_data;

    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;

    logic              m_valid, m_dirty, m_hit;
    logic [TAG_W-1:0]  m_tag;
    logic [DATA_W-1:0] m_data;
    logic              mw_en, mw_dirty;
    logic [DATA_W-1:0] mw_data;

    logic              vb_hit, vb_full;
    logic [SLOT_W-1:0] vb_hit_slot, vb_vic_slot, vb_rd_slot;
    logic              vb_rd_valid, vb_rd_dirty;
    logic [ADDR_W-1:0] vb_rd_addr;
    logic [DATA_W-1:0] vb_rd_data;
    logic              vw_en, vw_adv;

    assign r_idx = r_addr[IDX_W-1:0];
    assign r_tag = r_addr[ADDR_W-1:IDX_W];
    assign m_hit = m_valid && (m_tag == r_tag);

    dmvc_main_arr #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (r_idx),
        .rd_valid(m_valid),
        .rd_dirty(m_dirty),
        .rd_tag  (m_tag),
        .rd_data (m_data),
        .wr_en   (mw_en),
        .wr_idx  (r_idx),
        .wr_tag  (r_tag),
        .wr_dirty(mw_dirty),
        .wr_data (mw_data)
    );

    // Buffer read slot: in probe, the hit entry or the proposed victim.
    assign vb_rd_slot = (st_q == ST_PROBE) ? (vb_hit ? vb_hit_slot : vb_vic_slot)
                                           : s_slot;

    dmvc_victim_buf #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .DEPTH (VB_DEPTH),
        .SLOT_W(SLOT_W)
    ) u_vb (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_addr(r_addr),
        .hit       (vb_hit),
        .hit_slot  (vb_hit_slot),
        .full      (vb_full),
        .vic_slot  (vb_vic_slot),
        .rd_slot   (vb_rd_slot),
        .rd_valid  (vb_rd_valid),
        .rd_dirty  (vb_rd_dirty),
        .rd_addr   (vb_rd_addr),
        .rd_data   (vb_rd_data),
        .wr_en     (vw_en),
        .wr_slot   (s_slot),
        .wr_valid  (m_valid),
        .wr_dirty  (m_dirty),
        .wr_addr   ({m_tag, r_idx}),
        .wr_data   (m_data),
        .ptr_adv   (vw_adv)
    );

    // Next state and per-state outputs.
    always_comb begin
        st_d          = st_q;
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        resp_rdata    = r_wdata;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = r_addr;
        mem_req_wdata = vb_rd_data;
        mw_en         = 1'b0;
        mw_dirty      = 1'b0;
        mw_data       = r_wdata;
        vw_en         = 1'b0;
        vw_adv        = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) st_d = ST_LOOK;
            end
            ST_LOOK: begin
                if (m_hit) begin
                    resp_valid = 1'b1;
                    if (!r_write) resp_rdata = m_data;
                    mw_en    = r_write;
                    mw_dirty = 1'b1;
                    st_d     = ST_IDLE;
                end else begin
                    st_d = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (vb_hit)
                    st_d = ST_SWAP;
                else if (m_valid && vb_rd_valid && vb_rd_dirty)
                    st_d = ST_WBACK;
                else
                    st_d = ST_FILL;
            end
            ST_SWAP: begin
                resp_valid = 1'b1;
                if (!r_write) resp_rdata = vb_rd_data;
                mw_en    = 1'b1;
                mw_dirty = r_write | vb_rd_dirty;
                mw_data  = r_write ? r_wdata : vb_rd_data;
                vw_en    = 1'b1;
                st_d     = ST_IDLE;
            end
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = vb_rd_addr;
                if (mem_req_ready) st_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_resp_valid) st_d = ST_DONE;
            end
            ST_DONE: begin
                resp_valid = 1'b1;
                if (!r_write) resp_rdata = f_data;
                mw_en    = 1'b1;
                mw_dirty = r_write;
                mw_data  = r_write ? r_wdata : f_data;
                vw_en    = m_valid;
                vw_adv   = m_valid && vb_full;
                st_d     = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else if (st_q == ST_IDLE && req_valid) begin
            r_write <= req_write;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
        end
    end

    // Buffer slot chosen at probe time, used by swap, write-back and install.
    always_ff @(posedge clk) begin
        if (!rst_n)               s_slot <= '0;
        else if (st_q == ST_PROBE) s_slot <= vb_rd_slot;
    end

    // Fill data capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 f_data <= '0;
        else if (st_q == ST_WAIT && mem_resp_valid) f_data <= mem_resp_rdata;
    end

endmodule

// File: rtl/dmvc_cache_chk.sv
// Port-level protocol checks for dmvc_cache, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module dmvc_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata
);
    // R10: never ready while responding.
    a_r10_busy_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R10: idle again right after the response.
    a_r10_ready_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    // R2: the cycle after acceptance is a lookup, no memory request, not ready.
    a_r2_lookup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_req_valid && !req_ready));

    // R4: a stalled next-level request holds its fields.
    a_r4_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    // R9: an accepted write-back is followed at once by the fill read.
    a_r9_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_req_write) |=>
            (mem_req_valid && !mem_req_write));

    // R4: no response while a next-level request is pending.
    a_r4_no_resp_with_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !resp_valid);

endmodule

bind dmvc_cache dmvc_cache_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata)
);

// File: tb/dmvc_cache_tb_top.sv
// Bench: behavioural reference model (arrays, queues) compared every clock.
module dmvc_cache_tb_top;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NL = 64;
    localparam int VD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          resp_valid;
    logic [DW-1:0] resp_rdata;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_resp_valid = 1'b0;
    logic [DW-1:0] mem_resp_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk;  // 125 MHz

    dmvc_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .VB_DEPTH(VD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    // Next-level memory model
    logic [DW-1:0] mem_store [int];
    int            n_reads = 0;
    int            last_rd_addr = -1;
    int            wb_addr_q [$];
    logic [DW-1:0] wb_data_q [$];

    function automatic logic [DW-1:0] mem_get(int a);
        if (mem_store.exists(a)) return mem_store[a];
        return 32'hC0DE_0000 ^ (32'(a) * 32'h0001_0101);
    endfunction

    // Reference cache state
    bit            ref_mv [NL];
    bit            ref_md [NL];
    int            ref_mt [NL];
    logic [DW-1:0] ref_mdat [NL];
    bit            ref_vv [VD];
    bit            ref_vd [VD];
    int            ref_va [VD];
    logic [DW-1:0] ref_vdat [VD];
    int            ref_ptr = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Memory responder: one-cycle read latency, always ready.
    initial begin
        bit            pend = 0;
        int            paddr = 0;
        forever begin
            @(negedge clk);
            mem_resp_valid = pend;
            mem_resp_rdata = pend ? mem_get(paddr) : '0;
            pend = 0;
            if (rst_n && mem_req_valid) begin
                if (mem_req_write) begin
                    mem_store[int'(mem_req_addr)] = mem_req_wdata;
                    wb_addr_q.push_back(int'(mem_req_addr));
                    wb_data_q.push_back(mem_req_wdata);
                end else begin
                    pend = 1;
                    paddr = int'(mem_req_addr);
                    n_reads++;
                    last_rd_addr = int'(mem_req_addr);
                end
            end
        end
    end

    // Reference model of one access; updates model state.
    task automatic model(input bit wr, input int a, input logic [DW-1:0] d,
                         output int lat, output logic [DW-1:0] exp,
                         output bit has_wb, output int wba, output logic [DW-1:0] wbd,
                         output string cls);
        int idx = a % NL;
        int tag = a / NL;
        int k = -1;
        has_wb = 0; wba = 0; wbd = '0;
        if (ref_mv[idx] && ref_mt[idx] == tag) begin
            lat = 1; cls = "R2";
            if (wr) begin ref_mdat[idx] = d; ref_md[idx] = 1; end
            exp = wr ? d : ref_mdat[idx];
            return;
        end
        for (int i = 0; i < VD; i++) if (ref_vv[i] && ref_va[i] == a) k = i;
        if (k >= 0) begin
            bit tv = ref_vv[k]; bit td = ref_vd[k]; logic [DW-1:0] tdat = ref_vdat[k];
            lat = 3; cls = "R6";
            ref_vv[k] = ref_mv[idx]; ref_vd[k] = ref_md[idx];
            ref_va[k] = ref_mt[idx] * NL + idx; ref_vdat[k] = ref_mdat[idx];
            ref_mv[idx] = tv; ref_mt[idx] = tag;
            ref_md[idx] = td | wr;
            ref_mdat[idx] = wr ? d : tdat;
            exp = ref_mdat[idx];
            return;
        end
        begin
            int v = -1;
            bit all_v = 1;
            for (int i = VD - 1; i >= 0; i--) if (!ref_vv[i]) begin v = i; all_v = 0; end
            if (v < 0) v = ref_ptr;
            lat = 5; cls = "R4";
            if (ref_mv[idx]) begin
                if (ref_vv[v] && ref_vd[v]) begin
                    has_wb = 1; wba = ref_va[v]; wbd = ref_vdat[v]; lat = 6;
                end
                ref_vv[v] = 1; ref_vd[v] = ref_md[idx];
                ref_va[v] = ref_mt[idx] * NL + idx; ref_vdat[v] = ref_mdat[idx];
                if (all_v) ref_ptr = (ref_ptr + 1) % VD;
            end
            exp = wr ? d : mem_get(a);
            ref_mv[idx] = 1; ref_mt[idx] = tag; ref_md[idx] = wr;
            ref_mdat[idx] = exp;
        end
    endtask

    // Issue one request and compare the ports against the model each clock.
    task automatic do_req(input bit wr, input int a, input logic [DW-1:0] d);
        int lat; logic [DW-1:0] exp; bit has_wb; int wba; logic [DW-1:0] wbd;
        string cls; int rd0; int wb0;
        model(wr, a, d, lat, exp, has_wb, wba, wbd, cls);
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
        rd0 = n_reads; wb0 = wb_addr_q.size();
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        for (int n = 1; n <= lat; n++) begin
            if (n > 1) @(negedge clk);
            check(resp_valid == (n == lat), cls, $sformatf("resp_valid cycle %0d", n),
                  resp_valid, (n == lat));
            check(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
            if (n == lat && resp_valid)
                check(resp_rdata == exp, wr ? "R3" : cls, "resp_rdata", resp_rdata, exp);
        end
        @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0, "R10", "idle after response",
              {req_ready, resp_valid}, 2'b10);
        check(n_reads - rd0 == (lat >= 5), lat >= 5 ? "R4" : "R7", "fill reads",
              n_reads - rd0, (lat >= 5));
        if (lat >= 5)
            check(last_rd_addr == a, "R4", "fill address", last_rd_addr, a);
        check(wb_addr_q.size() - wb0 == int'(has_wb), "R8", "write-back count",
              wb_addr_q.size() - wb0, has_wb);
        if (has_wb && wb_addr_q.size() > wb0) begin
            check(wb_addr_q[wb0] == wba, "R9", "write-back address", wb_addr_q[wb0], wba);
            check(wb_data_q[wb0] == wbd, "R9", "write-back data", wb_data_q[wb0], wbd);
        end
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures",
                         n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1 && resp_valid == 0 && mem_req_valid == 0, "R1",
              "reset outputs", {req_ready, resp_valid, mem_req_valid}, 3'b100);

        // R1/R4: cold miss, then R2 hit
        do_req(0, 12'h005, '0);
        do_req(0, 12'h005, '0);
        // R5: conflicting line pushes first into buffer
        do_req(0, 12'h045, '0);
        // R6/R7: ping-pong between the two conflicting lines
        for (int i = 0; i < 4; i++) begin
            do_req(0, 12'h005, '0);
            do_req(0, 12'h045, '0);
        end
        do_req(0, 12'h045, '0);                 // R6 repeat hits in array
        // R3/R8: dirty the line, then move it through a swap
        do_req(1, 12'h005, 32'hDEAD_0005);
        do_req(0, 12'h045, '0);
        // R9: more conflicts fill the buffer and rotate; dirty line written back
        for (int t = 2; t < 9; t++) do_req(0, t * NL + 5, '0);
        // R3: write miss then read back
        do_req(1, 12'h3A1, 32'h1234_5678);
        do_req(0, 12'h3A1, '0);
        // R8: clean lines pushed out cause no write
        for (int t = 10; t < 16; t++) do_req(0, t * NL + 9, '0);
        // Mixed traffic over a few conflicting sets
        for (int i = 0; i < 300; i++) begin
            int a = (($urandom % 8) * NL) + 2 + ($urandom % 2);
            bit w = ($urandom % 3) == 0;
            do_req(w, a, $urandom);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule